// File: doc/BRIEF.md
# Stereo Channel Mixer with Ramped Volume

The block takes one left and one right signed 24-bit audio sample per strobe and produces two output channels, A and B. A 5-bit routing code picks, for each output, silence, the right input, the left input or the floored average of the two. Each output then passes through its own attenuator. The attenuator is driven by a 7-bit volume code in 1 dB steps, and its level is held internally in 1/8 dB units. A gain table and a saturating multiply apply that level to the sample.

A shared 2-bit policy sets how each channel's applied level moves towards its target. It can jump at once, jump at the next sign change of that channel's routed input, walk in 1/8 dB steps on a fixed sample cadence, or take one 1/8 dB step per sign change. Each channel detects sign changes on its own. A timeout forces the pending move when the input keeps one sign. The mute input and any volume code beyond the deepest setting send the target to a full-mute level, so muting follows the same policy. When auto-mute is enabled, a flag output reports that both channels sit at full mute.

Top module: `chmix_vol`

## Requirements
- R1: Routing code bits [3:2] pick the source of output A and bits [1:0] that of output B, with 00 silence, 01 right, 10 left and 11 floor((left+right)/2). When bit 4 is set, output B uses the bits [3:2] selection as well. The reset-friendly default 01001 routes left to A and right to B.
- R2: A sample accepted with valid_i high appears on the outputs at the next clock edge, with valid_o high for one cycle. Each output equals floor(s*c/65536), clamped to the 24-bit signed range, where s is the routed sample. c is round(65536*10^(-L/160)) for the channel level L (in 1/8 dB), and c is 0 at the full-mute level 760. The level used is the one held before that sample's own update.
- R3: The target level is 8*v for a volume code v in 0..94. A volume code above 94, or mute_i high, sets the target to 760, which gives zero output.
- R4: Policy 00 (immediate): at each sample the level becomes the target.
- R5: Policy 01 (zero cross): the level jumps to the target on a sample whose routed sign bit differs from that of the channel's previous sample. It also jumps once 16 consecutive pending samples have passed without a sign change (parameter ZC_TMO).
- R6: Policy 10 (soft ramp, default): while the level differs from the target, it moves one 1/8 dB step towards the target on every 2nd pending sample (parameter RAMP_N).
- R7: Policy 11 (stepped zero cross): it moves one 1/8 dB step towards the target on each sign change of the channel's input or on each timeout as in R5.
- R8: Sign-change detection, timeout and step timing are kept separately for A and B, so each channel moves only on its own input's sign changes.
- R9: mute_o is high exactly when amute_en_i is high and both channel levels equal 760.
- R10: After reset, both levels are 760, the outputs are 0 and valid_o is low. The previous-sign state is treated as non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample strobe |
| left_i | input | 24 | Left input sample, signed |
| right_i | input | 24 | Right input sample, signed |
| mix_i | input | 5 | Routing code |
| vol_a_i | input | 7 | Channel A attenuation in dB |
| vol_b_i | input | 7 | Channel B attenuation in dB |
| mute_i | input | 1 | Mute request for both channels |
| pol_i | input | 2 | Level change policy |
| amute_en_i | input | 1 | Enables the mute flag |
| valid_o | output | 1 | Output sample strobe |
| out_a_o | output | 24 | Channel A output, signed |
| out_b_o | output | 24 | Channel B output, signed |
| mute_o | output | 1 | Both channels fully muted |

## Verification
The level assertions take for granted that the policy and target inputs are stable when valid_i is sampled. They also assume that a level only moves on a strobe. The bench therefore changes the routing, volume, mute and policy inputs only in cycles where valid_i is low. Random samples and control codes are drawn from $urandom and include volume codes above 94 and every routing code. Directed runs hold one sign to force timeouts, or give the two channels different sign patterns.

// File: rtl/chmix_pkg.sv
package chmix_pkg;
  typedef enum logic [1:0] {
    POL_IMM  = 2'b00,
    POL_ZC   = 2'b01,
    POL_SOFT = 2'b10,
    POL_ZCS  = 2'b11
  } policy_e;
endpackage

// File: rtl/chmix_route.sv
module chmix_route #(
  parameter int DW = 24
) (
  input  logic signed [DW-1:0] left_i,
  input  logic signed [DW-1:0] right_i,
  input  logic [1:0]           sel_i,
  output logic signed [DW-1:0] smp_o
);
  logic signed [DW:0] sum;
  assign sum = {left_i[DW-1], left_i} + {right_i[DW-1], right_i};

  always_comb begin
    unique case (sel_i)
      2'b00:   smp_o = '0;
      2'b01:   smp_o = right_i;
      2'b10:   smp_o = left_i;
      default: smp_o = sum[DW:1];  // floor of average
    endcase
  end
endmodule

// File: rtl/chmix_level.sv
module chmix_level import chmix_pkg::*; #(
  parameter int LW       = 10,
  parameter int MUTE_LVL = 760,
  parameter int RAMP_N   = 2,
  parameter int ZC_TMO   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          sign_i,
  input  logic [LW-1:0] tgt_i,
  input  logic [1:0]    pol_i,
  output logic [LW-1:0] lvl_o
);
  localparam int RW = $clog2(RAMP_N + 1);
  localparam int TW = $clog2(ZC_TMO + 1);

  logic [LW-1:0] lvl_q, toward;
  logic [RW-1:0] rcnt_q;
  logic [TW-1:0] tcnt_q;
  logic          prev_neg_q, pend, zc, evt;

  assign pend   = (lvl_q != tgt_i);
  assign zc     = (sign_i != prev_neg_q);
  assign evt    = zc || (tcnt_q == TW'(ZC_TMO - 1));
  assign toward = (tgt_i > lvl_q) ? lvl_q + LW'(1) : lvl_q - LW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q      <= LW'(MUTE_LVL);
      rcnt_q     <= '0;
      tcnt_q     <= '0;
      prev_neg_q <= 1'b0;
    end else if (step_i) begin
      prev_neg_q <= sign_i;
      if (!pend) begin
        rcnt_q <= '0;
        tcnt_q <= '0;
      end else begin
        unique case (policy_e'(pol_i))
          POL_IMM: lvl_q <= tgt_i;
          POL_ZC: begin
            if (evt) begin
              lvl_q  <= tgt_i;
              tcnt_q <= '0;
            end else tcnt_q <= tcnt_q + TW'(1);
          end
          POL_SOFT: begin
            if (rcnt_q == RW'(RAMP_N - 1)) begin
              lvl_q  <= toward;
              rcnt_q <= '0;
            end else rcnt_q <= rcnt_q + RW'(1);
          end
          default: begin
            if (evt) begin
              lvl_q  <= toward;
              tcnt_q <= '0;
            end else tcnt_q <= tcnt_q + TW'(1);
          end
        endcase
      end
    end
  end

  assign lvl_o = lvl_q;

  // R4
  imm_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && pol_i == POL_IMM) |=> (lvl_q == $past(tgt_i)));
  // R6
  soft_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (pol_i == POL_SOFT || pol_i == POL_ZCS)) |=>
    (lvl_q == $past(lvl_q) || lvl_q == $past(lvl_q) + LW'(1) || lvl_q == $past(lvl_q) - LW'(1)));
  // R2
  hold_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(lvl_q));
  // R3
  lvl_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LW'(MUTE_LVL));
endmodule

// File: rtl/chmix_gain.sv
module chmix_gain #(
  parameter int DW       = 24,
  parameter int LW       = 10,
  parameter int MUTE_LVL = 760,
  parameter int Q        = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic signed [DW-1:0] smp_i,
  input  logic [LW-1:0]        lvl_i,
  output logic signed [DW-1:0] out_o
);
  localparam int  CW    = Q + 1;
  localparam int  PW    = DW + CW + 1;
  localparam real SCALE = 2.0 ** Q;
  localparam logic signed [PW-1:0] SAT_HI = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] SAT_LO = ~SAT_HI;

  logic [CW-1:0] coef_tab [MUTE_LVL];
  logic [CW-1:0] coef;
  logic signed [PW-1:0] prod, shifted;
  logic signed [DW-1:0] sat;

  for (genvar g = 0; g < MUTE_LVL; g++) begin : g_coef
    localparam real GAIN_R = 10.0 ** (-real'(g) / 160.0);
    assign coef_tab[g] = CW'($rtoi(GAIN_R * SCALE + 0.5));
  end

  assign coef    = (lvl_i >= LW'(MUTE_LVL)) ? '0 : coef_tab[lvl_i];
  assign prod    = PW'(smp_i) * $signed({1'b0, coef});
  assign shifted = prod >>> Q;

  always_comb begin
    if (shifted > SAT_HI)      sat = SAT_HI[DW-1:0];
    else if (shifted < SAT_LO) sat = SAT_LO[DW-1:0];
    else                       sat = shifted[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_o <= '0;
    else if (step_i) out_o <= sat;
  end

  // R3
  mute_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && lvl_i == LW'(MUTE_LVL)) |=> (out_o == '0));
endmodule

// File: rtl/chmix_vol.sv
module chmix_vol import chmix_pkg::*; #(
  parameter int DW      = 24,
  parameter int VW      = 7,
  parameter int MAX_VOL = 94,
  parameter int RAMP_N  = 2,
  parameter int ZC_TMO  = 16,
  parameter int Q       = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] left_i,
  input  logic signed [DW-1:0] right_i,
  input  logic [4:0]           mix_i,
  input  logic [VW-1:0]        vol_a_i,
  input  logic [VW-1:0]        vol_b_i,
  input  logic                 mute_i,
  input  logic [1:0]           pol_i,
  input  logic                 amute_en_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] out_a_o,
  output logic signed [DW-1:0] out_b_o,
  output logic                 mute_o
);
  localparam int MUTE_LVL = 8 * (MAX_VOL + 1);
  localparam int LW       = $clog2(MUTE_LVL + 1);

  logic [1:0]           sel    [2];
  logic [VW-1:0]        vol    [2];
  logic [LW-1:0]        tgt    [2];
  logic [LW-1:0]        lvl    [2];
  logic signed [DW-1:0] mixed  [2];
  logic signed [DW-1:0] out_ch [2];

  assign sel[0] = mix_i[3:2];
  assign sel[1] = mix_i[4] ? mix_i[3:2] : mix_i[1:0];
  assign vol[0] = vol_a_i;
  assign vol[1] = vol_b_i;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign tgt[c] = (mute_i || int'(vol[c]) > MAX_VOL) ? LW'(MUTE_LVL)
                                                       : LW'(vol[c]) << 3;

    chmix_route #(.DW(DW)) u_route (
      .left_i (left_i),
      .right_i(right_i),
      .sel_i  (sel[c]),
      .smp_o  (mixed[c])
    );

    chmix_level #(.LW(LW), .MUTE_LVL(MUTE_LVL), .RAMP_N(RAMP_N), .ZC_TMO(ZC_TMO)) u_level (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .step_i(valid_i),
      .sign_i(mixed[c][DW-1]),
      .tgt_i (tgt[c]),
      .pol_i (pol_i),
      .lvl_o (lvl[c])
    );

    chmix_gain #(.DW(DW), .LW(LW), .MUTE_LVL(MUTE_LVL), .Q(Q)) u_gain (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .step_i(valid_i),
      .smp_i (mixed[c]),
      .lvl_i (lvl[c]),
      .out_o (out_ch[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assign out_a_o = out_ch[0];
  assign out_b_o = out_ch[1];
  assign mute_o  = amute_en_i && lvl[0] == LW'(MUTE_LVL) && lvl[1] == LW'(MUTE_LVL);

  // R9
  mute_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mute_o) |=> (out_a_o == '0 && out_b_o == '0));
  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

// File: tb/chmix_vol_tb_top.sv
module chmix_vol_tb_top;
  localparam int RAMP_N = 2;
  localparam int ZC_TMO = 16;
  localparam int MUTE_L = 760;

  logic clk = 0, rst_n = 0, valid = 0, mute = 0, amute = 1;
  logic signed [23:0] left = 0, right = 0;
  logic [4:0] mix = 5'b01001;
  logic [6:0] vol_a = 0, vol_b = 0;
  logic [1:0] pol = 2'b10;
  logic valid_o, mute_o;
  logic signed [23:0] out_a, out_b;

  int nchk = 0, nerr = 0;
  bit done = 0;
  int mlvl [2], mt [2], mr [2];
  bit mprev [2];

  always #5 clk = ~clk;

  chmix_vol #(.RAMP_N(RAMP_N), .ZC_TMO(ZC_TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .left_i(left), .right_i(right),
    .mix_i(mix), .vol_a_i(vol_a), .vol_b_i(vol_b), .mute_i(mute), .pol_i(pol),
    .amute_en_i(amute), .valid_o(valid_o), .out_a_o(out_a), .out_b_o(out_b), .mute_o(mute_o));

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint mixf(input int c);
    logic [1:0] s = (c == 0 || mix[4]) ? mix[3:2] : mix[1:0];
    case (s)
      2'b00:   return 0;
      2'b01:   return longint'(right);
      2'b10:   return longint'(left);
      default: return (longint'(left) + longint'(right)) >>> 1;
    endcase
  endfunction

  function automatic longint gainf(input longint m, input int lvl);
    longint c, p;
    if (lvl >= MUTE_L) c = 0;
    else c = longint'($rtoi(10.0 ** (-real'(lvl) / 160.0) * 65536.0 + 0.5));
    p = (m * c) >>> 16;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return p;
  endfunction

  task automatic upd(input int c, input longint m);
    int v = (c == 0) ? int'(vol_a) : int'(vol_b);
    int tgt = (mute || v > 94) ? MUTE_L : v * 8;
    bit neg = (m < 0);
    bit evt = (neg != mprev[c]) || (mt[c] == ZC_TMO - 1);
    int tw = (tgt > mlvl[c]) ? mlvl[c] + 1 : mlvl[c] - 1;
    if (mlvl[c] == tgt) begin
      mt[c] = 0; mr[c] = 0;
    end else case (pol)
      2'b00: mlvl[c] = tgt;
      2'b01: if (evt) begin mlvl[c] = tgt; mt[c] = 0; end else mt[c]++;
      2'b10: if (mr[c] == RAMP_N - 1) begin mlvl[c] = tw; mr[c] = 0; end else mr[c]++;
      default: if (evt) begin mlvl[c] = tw; mt[c] = 0; end else mt[c]++;
    endcase
    mprev[c] = neg;
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic smp(input logic signed [23:0] l, input logic signed [23:0] r, input string tag);
    longint e [2];
    left = l; right = r; valid = 1;
    for (int c = 0; c < 2; c++) begin
      longint m = mixf(c);
      e[c] = gainf(m, mlvl[c]);
      upd(c, m);
    end
    @(negedge clk);
    valid = 0;
    chk("R2 valid", longint'(valid_o), 1);
    chk({tag, " out_a"}, longint'(out_a), e[0]);
    chk({tag, " out_b"}, longint'(out_b), e[1]);
    chk("R9 mute_o", longint'(mute_o),
        longint'(amute && mlvl[0] == MUTE_L && mlvl[1] == MUTE_L));
  endtask

  function automatic logic signed [23:0] rnd();
    return $signed(24'($urandom()));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4341));
    for (int c = 0; c < 2; c++) begin mlvl[c] = MUTE_L; mt[c] = 0; mr[c] = 0; mprev[c] = 0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid_o", longint'(valid_o), 0);
    chk("R10 out_a", longint'(out_a), 0);
    chk("R10 out_b", longint'(out_b), 0);
    chk("R10 mute_o", longint'(mute_o), 1);
    rst_n = 1;
    @(negedge clk);
    chk("R10 idle", longint'(valid_o), 0);

    // R4 immediate, default routing
    pol = 2'b00;
    for (int i = 0; i < 30; i++) smp(rnd(), rnd(), "R4");

    // R1 / R3 random routing and volume
    for (int i = 0; i < 300; i++) begin
      mix = 5'($urandom()); vol_a = 7'($urandom_range(0, 100)); vol_b = 7'($urandom_range(0, 100));
      mute = ($urandom_range(0, 7) == 0);
      smp(rnd(), rnd(), "R1");
    end
    mute = 0; mix = 5'b01111; vol_a = 0; vol_b = 0;
    smp(24'sd0, 24'sd0, "R1");
    smp(-24'sd3, 24'sd0, "R1 avg floor");
    mix = 5'b11001;
    smp(24'sd100, 24'sd7, "R1 bit4");
    mix = 5'b01001; vol_a = 95; vol_b = 94;
    smp(24'sd8000000, 24'sd8000000, "R3");
    smp(24'sd8000000, 24'sd8000000, "R3 deep");

    // R9 flag gating
    mute = 1;
    smp(rnd(), rnd(), "R9");
    amute = 0;
    smp(rnd(), rnd(), "R9 off");
    amute = 1;
    smp(rnd(), rnd(), "R9 on");
    mute = 0; vol_a = 10; vol_b = 10;

    // R5 zero cross with timeout
    pol = 2'b01;
    for (int i = 0; i < 20; i++) smp(24'sd1000, 24'sd1000, "R5 tmo");
    vol_a = 30; vol_b = 30;
    for (int i = 0; i < 10; i++) smp((i % 2) ? -24'sd500 : 24'sd500, (i % 2) ? 24'sd500 : -24'sd500, "R5");

    // R8 independent channels
    vol_a = 0; vol_b = 0;
    for (int i = 0; i < 10; i++) smp(24'sd2000, (i % 2) ? -24'sd2000 : 24'sd2000, "R8");
    vol_a = 40; vol_b = 40;
    for (int i = 0; i < 20; i++) smp(24'sd2000, (i % 2) ? -24'sd2000 : 24'sd2000, "R8");

    // R6 soft ramp out of mute
    pol = 2'b00; mute = 1;
    smp(rnd(), rnd(), "R6 prep");
    pol = 2'b10; mute = 0; vol_a = 0; vol_b = 0;
    for (int i = 0; i < 1560; i++) smp(rnd(), rnd(), "R6");
    vol_a = 3; vol_b = 5;
    for (int i = 0; i < 90; i++) smp(rnd(), rnd(), "R6 down");

    // R7 stepped zero cross
    pol = 2'b11; vol_a = 12; vol_b = 2;
    for (int i = 0; i < 300; i++) smp(rnd(), rnd(), "R7");
    vol_a = 20;
    for (int i = 0; i < 200; i++) smp(24'sd3000, 24'sd3000, "R7 tmo");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule